// File: doc/BRIEF.md
# Multicycle Processor Main Controller

This block is the sequencing controller of a small multicycle processor whose datapath has one memory shared by instructions and data, and one ALU that also advances the program counter. Each clock cycle the controller drives the datapath select and write-enable lines. It decides from the instruction's opcode and function fields which stages that instruction needs, and skips the rest.

Every instruction starts with a fetch cycle and a decode cycle. In the fetch cycle the memory is read at the PC and the ALU adds four to the PC. In the decode cycle the ALU adds the sign-extended immediate to the already advanced PC, and the sum is stored in a target register for a possible branch. After decode, the controller visits execute, memory and writeback only when the instruction needs them. Loads and stores compute the address Reg[rs] + immediate. A branch-on-equal compares rs and rt and loads the buffered target when they match. A jump-register loads Reg[rs] into the PC. Any encoding not listed below goes straight back to fetch without writing anything.

Top module: `mc_ctrl`

Encodings: opcode 0x00 is register-register, with function codes add 0x20, sub 0x22, and 0x24, or 0x25, set-less-than 0x2A, shift-left 0x00 and jump-register 0x08. The other opcodes are load 0x23, store 0x2B, branch-equal 0x04 and set-less-than-immediate 0x0A. Select codes: pc_src 0 = ALU result, 1 = target register, 2 = Reg[rs]. alu_a_sel 0 = PC, 1 = rs, 2 = rt. alu_b_sel 0 = rt, 1 = constant four, 2 = immediate, 3 = shift amount. alu_op 0 add, 1 sub, 2 and, 3 or, 4 set-less-than, 5 shift-left. Any control not named for a cycle below is 0.

## Requirements
- R1: In the first cycle after reset, and in the first cycle of every instruction (fetch), the controller drives mem_rd=1, ir_wr=1, pc_wr=1, pc_src=0, addr_sel=0, alu_a_sel=0, alu_b_sel=1 and alu_op=0.
- R2: The cycle after fetch is always decode: tgt_wr=1, alu_a_sel=0, alu_b_sel=2, alu_op=0, and no PC, register or memory write.
- R3: addr_sel is 0 whenever memory is read for an instruction and 1 in the memory-access cycle of a load or a store. A read and a write are never requested in the same cycle.
- R4: A branch-equal executes with alu_a_sel=1, alu_b_sel=0, alu_op=1 and pc_src=1, and pc_wr equal to the zero input. The next cycle is fetch.
- R5: A load takes five cycles. Execute has alu_a_sel=1, alu_b_sel=2 and alu_op=0. The memory cycle has mem_rd=1 and addr_sel=1. Writeback has reg_wr=1, reg_dst=0 and wb_src=1.
- R6: A store takes four cycles. Execute is the same as for a load, the memory cycle has mem_wr=1 and addr_sel=1, and fetch follows with no writeback.
- R7: A jump-register takes three cycles. Its execute cycle has pc_wr=1 and pc_src=2, and fetch follows.
- R8: A register-register add, sub, and, or or set-less-than takes four cycles. Execute has alu_a_sel=1, alu_b_sel=0 and the matching alu_op. Writeback has reg_wr=1, reg_dst=1 and wb_src=0.
- R9: A shift-left takes four cycles. Execute has alu_a_sel=2, alu_b_sel=3 and alu_op=5. Writeback is the same as in R8.
- R10: A set-less-than-immediate takes four cycles. Execute has alu_a_sel=1, alu_b_sel=2 and alu_op=4. Writeback has reg_wr=1, reg_dst=0 and wb_src=0.
- R11: An unknown opcode, or an unknown function code under opcode 0x00, returns to fetch right after decode, with no register, memory or PC write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| pc_wr | output | 1 | PC write enable |
| pc_src | output | 2 | PC input select |
| tgt_wr | output | 1 | Branch target register write enable |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| ir_wr | output | 1 | Instruction register write enable |
| reg_wr | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| wb_src | output | 1 | Write-back data: 0 ALU output, 1 memory data |
| alu_a_sel | output | 2 | ALU first operand select |
| alu_b_sel | output | 2 | ALU second operand select |
| alu_op | output | 3 | ALU operation |

## Verification
The assertions check ordering rules on every cycle. Decode always follows fetch. A PC load from the target register only happens right after a decode and only with the zero flag set. Data accesses use the ALU address set up by an immediate-based execute. A store goes straight back to fetch, and a register write never directly follows fetch or decode. Only the bench scenarios can show the full per-cycle control word of each instruction type: the instruction's length, which stages it skips, how the ALU operation follows the function code, both outcomes of the branch, and the handling of unknown encodings.

// File: rtl/mc_ctrl.sv
module mc_ctrl #(
  parameter logic [5:0] OP_REG   = 6'h00,
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2B,
  parameter logic [5:0] OP_BEQ   = 6'h04,
  parameter logic [5:0] OP_SLTI  = 6'h0A,
  parameter logic [5:0] FN_ADD   = 6'h20,
  parameter logic [5:0] FN_SUB   = 6'h22,
  parameter logic [5:0] FN_AND   = 6'h24,
  parameter logic [5:0] FN_OR    = 6'h25,
  parameter logic [5:0] FN_SLT   = 6'h2A,
  parameter logic [5:0] FN_SLL   = 6'h00,
  parameter logic [5:0] FN_JR    = 6'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       zero,
  output logic       addr_sel,
  output logic       pc_wr,
  output logic [1:0] pc_src,
  output logic       tgt_wr,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       reg_wr,
  output logic       reg_dst,
  output logic       wb_src,
  output logic [1:0] alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [2:0] alu_op
);

  localparam logic [1:0] A_PC = 2'd0, A_RS = 2'd1, A_RT = 2'd2;
  localparam logic [1:0] B_RT = 2'd0, B_FOUR = 2'd1, B_IMM = 2'd2, B_SHAMT = 2'd3;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2,
                         OP_OR = 3'd3, OP_SLT = 3'd4, OP_SHL = 3'd5;
  localparam logic [1:0] PCS_ALU = 2'd0, PCS_TGT = 2'd1, PCS_RS = 2'd2;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB} state_t;
  state_t state, state_nx;

  logic is_reg, is_alu_r, is_sll, is_jr, is_ld, is_st, is_beq, is_slti;
  logic need_ex, need_mem, need_wb;
  logic [2:0] r_op;

  assign is_reg   = (opcode == OP_REG);
  assign is_alu_r = is_reg && (funct inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT});
  assign is_sll   = is_reg && (funct == FN_SLL);
  assign is_jr    = is_reg && (funct == FN_JR);
  assign is_ld    = (opcode == OP_LOAD);
  assign is_st    = (opcode == OP_STORE);
  assign is_beq   = (opcode == OP_BEQ);
  assign is_slti  = (opcode == OP_SLTI);

  assign need_ex  = is_ld | is_st | is_alu_r | is_sll | is_jr | is_slti | is_beq;
  assign need_mem = is_ld | is_st;
  assign need_wb  = is_ld | is_alu_r | is_sll | is_slti;

  always_comb begin
    unique case (funct)
      FN_SUB:  r_op = OP_SUB;
      FN_AND:  r_op = OP_AND;
      FN_OR:   r_op = OP_OR;
      FN_SLT:  r_op = OP_SLT;
      default: r_op = OP_ADD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= state_nx;
  end

  always_comb begin
    unique case (state)
      S_FETCH:  state_nx = S_DECODE;
      S_DECODE: state_nx = need_ex ? S_EXEC : S_FETCH;
      S_EXEC:   state_nx = need_mem ? S_MEM : (need_wb ? S_WB : S_FETCH);
      S_MEM:    state_nx = need_wb ? S_WB : S_FETCH;
      default:  state_nx = S_FETCH;
    endcase
  end

  always_comb begin
    addr_sel  = 1'b0;
    pc_wr     = 1'b0;
    pc_src    = PCS_ALU;
    tgt_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    ir_wr     = 1'b0;
    reg_wr    = 1'b0;
    reg_dst   = 1'b0;
    wb_src    = 1'b0;
    alu_a_sel = A_PC;
    alu_b_sel = B_RT;
    alu_op    = OP_ADD;
    unique case (state)
      S_FETCH: begin
        mem_rd    = 1'b1;
        ir_wr     = 1'b1;
        pc_wr     = 1'b1;
        alu_b_sel = B_FOUR;
      end
      S_DECODE: begin
        tgt_wr    = 1'b1;
        alu_b_sel = B_IMM;
      end
      S_EXEC: begin
        if (is_ld || is_st) begin
          alu_a_sel = A_RS;
          alu_b_sel = B_IMM;
        end else if (is_alu_r) begin
          alu_a_sel = A_RS;
          alu_op    = r_op;
        end else if (is_sll) begin
          alu_a_sel = A_RT;
          alu_b_sel = B_SHAMT;
          alu_op    = OP_SHL;
        end else if (is_slti) begin
          alu_a_sel = A_RS;
          alu_b_sel = B_IMM;
          alu_op    = OP_SLT;
        end else if (is_beq) begin
          alu_a_sel = A_RS;
          alu_op    = OP_SUB;
          pc_src    = PCS_TGT;
          pc_wr     = zero;
        end else if (is_jr) begin
          pc_src    = PCS_RS;
          pc_wr     = 1'b1;
        end
      end
      S_MEM: begin
        addr_sel = 1'b1;
        mem_rd   = is_ld;
        mem_wr   = is_st;
      end
      S_WB: begin
        reg_wr  = 1'b1;
        reg_dst = is_alu_r | is_sll;
        wb_src  = is_ld;
      end
      default: ;
    endcase
  end

  AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (tgt_wr && !ir_wr && !pc_wr)); // R2
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R3
  AST_DATA_ADDR_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || (mem_rd && !ir_wr)) |-> (addr_sel && $past(alu_b_sel) == B_IMM)); // R3
  AST_TARGET_LOAD_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PCS_TGT) |-> ($past(tgt_wr) && zero)); // R4
  AST_STORE_SKIPS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (ir_wr && !reg_wr)); // R6
  AST_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (!$past(ir_wr) && !$past(tgt_wr) && !$past(reg_wr))); // R8

endmodule

// File: tb/mc_ctrl_bench.sv
module mc_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = '0, funct = '0;
  logic zero = 1'b0;
  logic addr_sel, pc_wr, tgt_wr, mem_rd, mem_wr, ir_wr, reg_wr, reg_dst, wb_src;
  logic [1:0] pc_src, alu_a_sel, alu_b_sel;
  logic [2:0] alu_op;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam int K_LD = 0, K_ST = 1, K_ALU = 2, K_SLL = 3, K_JR = 4,
                 K_SLTI = 5, K_BEQ = 6, K_BAD = 7;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl u_mc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .zero(zero),
    .addr_sel(addr_sel), .pc_wr(pc_wr), .pc_src(pc_src), .tgt_wr(tgt_wr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
    .reg_dst(reg_dst), .wb_src(wb_src), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );

  wire [17:0] act = {addr_sel, pc_wr, pc_src, tgt_wr, mem_rd, mem_wr, ir_wr,
                     reg_wr, reg_dst, wb_src, alu_a_sel, alu_b_sel, alu_op};

  function automatic int kind_of(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'h23) return K_LD;
    if (op == 6'h2B) return K_ST;
    if (op == 6'h04) return K_BEQ;
    if (op == 6'h0A) return K_SLTI;
    if (op == 6'h00) begin
      if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A) return K_ALU;
      if (fn == 6'h00) return K_SLL;
      if (fn == 6'h08) return K_JR;
    end
    return K_BAD;
  endfunction

  function automatic int len_of(input int k);
    case (k)
      K_LD: return 5;
      K_JR, K_BEQ: return 3;
      K_BAD: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic string req_of(input int k, input int step);
    if (step == 0) return "R1";
    if (step == 1) return "R2";
    case (k)
      K_LD: return (step == 3) ? "R3 R5" : "R5";
      K_ST: return (step == 3) ? "R3 R6" : "R6";
      K_ALU: return "R8";
      K_SLL: return "R9";
      K_JR: return "R7";
      K_SLTI: return "R10";
      K_BEQ: return "R4";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [17:0] exp_word(input int k, input int step,
                                           input logic z, input logic [5:0] fn);
    logic as = 0, pw = 0, tw = 0, mr = 0, mw = 0, ir = 0, rw = 0, rd = 0, ws = 0;
    logic [1:0] ps = 0, a = 0, b = 0;
    logic [2:0] op = 0;
    case (step)
      0: begin mr = 1; ir = 1; pw = 1; b = 2'd1; end
      1: begin tw = 1; b = 2'd2; end
      2: case (k)
           K_LD, K_ST: begin a = 2'd1; b = 2'd2; end
           K_ALU: begin
             a = 2'd1;
             op = (fn == 6'h22) ? 3'd1 : (fn == 6'h24) ? 3'd2 :
                  (fn == 6'h25) ? 3'd3 : (fn == 6'h2A) ? 3'd4 : 3'd0;
           end
           K_SLL: begin a = 2'd2; b = 2'd3; op = 3'd5; end
           K_JR: begin pw = 1; ps = 2'd2; end
           K_SLTI: begin a = 2'd1; b = 2'd2; op = 3'd4; end
           K_BEQ: begin a = 2'd1; op = 3'd1; ps = 2'd1; pw = z; end
           default: ;
         endcase
      3: case (k)
           K_LD: begin as = 1; mr = 1; end
           K_ST: begin as = 1; mw = 1; end
           K_ALU, K_SLL: begin rw = 1; rd = 1; end
           K_SLTI: rw = 1;
           default: ;
         endcase
      4: if (k == K_LD) begin rw = 1; ws = 1; end
      default: ;
    endcase
    return {as, pw, ps, tw, mr, mw, ir, rw, rd, ws, a, b, op};
  endfunction

  task automatic check(input string req, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", req, opcode, funct, act, exp);
    end
  endtask

  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic z);
    int k;
    k = kind_of(op, fn);
    opcode = op; funct = fn; zero = z;
    for (int s = 0; s < len_of(k); s++) begin
      check(req_of(k, s), exp_word(k, s, z, fn));
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] op, fn;
    int pick;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", exp_word(K_BAD, 0, 1'b0, 6'h0));
    run_instr(6'h23, 6'h15, 1'b0);
    run_instr(6'h2B, 6'h3F, 1'b1);
    run_instr(6'h00, 6'h20, 1'b0);
    run_instr(6'h00, 6'h22, 1'b1);
    run_instr(6'h00, 6'h24, 1'b0);
    run_instr(6'h00, 6'h25, 1'b0);
    run_instr(6'h00, 6'h2A, 1'b0);
    run_instr(6'h00, 6'h00, 1'b1);
    run_instr(6'h00, 6'h08, 1'b0);
    run_instr(6'h0A, 6'h01, 1'b1);
    run_instr(6'h04, 6'h00, 1'b1);
    run_instr(6'h04, 6'h00, 1'b0);
    run_instr(6'h3F, 6'h20, 1'b1);
    run_instr(6'h00, 6'h3F, 1'b1);
    run_instr(6'h04, 6'h08, 1'b1);
    for (int i = 0; i < 400; i++) begin
      pick = $urandom % 10;
      fn = 6'($urandom);
      case (pick)
        0: op = 6'h23;
        1: op = 6'h2B;
        2: op = 6'h04;
        3: op = 6'h0A;
        4: begin op = 6'h00; fn = 6'h20 + 6'(2 * ($urandom % 3)); end
        5: begin op = 6'h00; fn = ($urandom % 2) ? 6'h25 : 6'h2A; end
        6: begin op = 6'h00; fn = ($urandom % 2) ? 6'h00 : 6'h08; end
        7: op = 6'h00;
        default: op = 6'($urandom);
      endcase
      run_instr(op, fn, 1'($urandom));
    end
    check("R1", exp_word(K_BAD, 0, 1'b0, 6'h0));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule